// File: doc/BRIEF.md
# Dual Memory Self-Test Control Register

This block holds one byte-wide test-control register that launches and reports built-in self-test on two on-chip memories: a code store and a data store. Each store has its own march sequencer working on a small synchronous RAM model inside the block. A host reaches the register through a plain register port: address, write strobe, write data and combinational read data.

Setting a store's enable bit starts its sequencer. The sequencer first fills the RAM with zeros. It then makes an ascending pass that reads 0 and writes all-ones at each address. Last it makes a descending pass that reads all-ones and writes 0. When the run ends, the store's done flag rises and stays up until the host clears the enable. The error flag reports a mismatch, but only while both enable and done are high.

Two test-only inputs pin bit 0 of one RAM word high in either store. They exist so that fault detection can be exercised.

Top module: `dual_mbist_ctl`

## Requirements
- R1: After reset the register at address 0xA6 reads 0x00. A read at any other address returns 0x00.
- R2: Bit layout: bit 0 is code enable, bit 1 code done and bit 2 code error. Bit 4 is data enable, bit 5 data done and bit 6 data error. Bits 3 and 7 always read 0.
- R3: Only bits 0 and 4 are writable. Written values in bits 1-3 and 5-7 are ignored. Writes to any address other than 0xA6 change nothing.
- R4: A done flag reads 1 exactly 5*DEPTH+1 clock edges after the write edge that raised its enable from 0 to 1. It holds while the enable stays 1 and reads 0 once the enable is written 0.
- R5: An error flag reads 0 whenever its enable or its done flag is 0.
- R6: The sequencer runs three passes: a zero background fill, an ascending read-0/write-ones pass and a descending read-ones/write-0 pass. Any read mismatch sets an error that stays set for the rest of that run.
- R7: Writing 0x11 runs both sequencers at once. A fault-free result reads 0x33.
- R8: Clearing an enable during a run aborts that sequencer at once. Enabling it again starts a full new run with the full R4 latency.
- R9: With the stuck bit injected into one store only, a completed dual run reads 0x37 (code fault) or 0x73 (data fault). The other store's error bit stays 0.
- R10: Starting a new run clears the error left by an earlier run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational on reg_addr |
| code_fault | input | 1 | Test input: pins bit 0 of code RAM word FAULT_ADDR high on read |
| data_fault | input | 1 | Test input: pins bit 0 of data RAM word FAULT_ADDR high on read |

## Verification
The hardest situation to reach is a mid-run abort followed by a restart. The bench drops an enable partway through the ascending pass and re-raises it. It then checks that done appears only after a complete fresh run, and never at the time the aborted run would have ended. A second hard case is a fault whose error bit is set long before done but must stay hidden until done. The bench holds one fault input across a full run and compares the register on every clock against a behavioural countdown model, so any early or leaked error bit is caught in the cycle it appears.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BG,
        ST_UP_RD,
        ST_UP_WR,
        ST_DN_RD,
        ST_DN_WR,
        ST_DONE
    } march_st_e;

    localparam int NUM_ENGINES = 2;
    localparam int FIELD_W     = 4;

endpackage

// File: rtl/march_ram.sv
module march_ram #(
    parameter int DEPTH      = 64,
    parameter int WIDTH      = 8,
    parameter int FAULT_ADDR = 5,
    localparam int AW        = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic             re,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             fault,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [WIDTH-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (re) begin
            rdata_d = mem[addr];
            if (fault && addr == AW'(FAULT_ADDR)) begin
                rdata_d[0] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

    assert_no_rw_collision_R6: assert property (@(posedge clk) !(we && re));

endmodule

// File: rtl/march_engine.sv
module march_engine
    import mbist_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int WIDTH      = 8,
    parameter int FAULT_ADDR = 5,
    localparam int AW        = $clog2(DEPTH)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic fault_i,
    output logic done_o,
    output logic err_o
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        march_st_e   st;
        logic [AW-1:0] addr;
        logic        err;
        logic        prev;
    } eng_s;

    eng_s s_d, s_q;
    logic             ram_we, ram_re;
    logic [WIDTH-1:0] ram_wdata, ram_rdata;

    always_comb begin
        s_d       = s_q;
        s_d.prev  = en_i;
        ram_we    = 1'b0;
        ram_re    = 1'b0;
        ram_wdata = '0;
        if (!en_i) begin
            s_d.st   = ST_IDLE;
            s_d.addr = '0;
        end else begin
            unique case (s_q.st)
                ST_IDLE: begin
                    if (!s_q.prev) begin
                        s_d.st   = ST_BG;
                        s_d.addr = '0;
                        s_d.err  = 1'b0;
                    end
                end
                ST_BG: begin
                    ram_we = 1'b1;
                    if (s_q.addr == LAST) begin
                        s_d.st   = ST_UP_RD;
                        s_d.addr = '0;
                    end else begin
                        s_d.addr = s_q.addr + 1'b1;
                    end
                end
                ST_UP_RD: begin
                    ram_re = 1'b1;
                    s_d.st = ST_UP_WR;
                end
                ST_UP_WR: begin
                    if (ram_rdata != '0) s_d.err = 1'b1;
                    ram_we    = 1'b1;
                    ram_wdata = '1;
                    if (s_q.addr == LAST) begin
                        s_d.st = ST_DN_RD;
                    end else begin
                        s_d.st   = ST_UP_RD;
                        s_d.addr = s_q.addr + 1'b1;
                    end
                end
                ST_DN_RD: begin
                    ram_re = 1'b1;
                    s_d.st = ST_DN_WR;
                end
                ST_DN_WR: begin
                    if (ram_rdata != '1) s_d.err = 1'b1;
                    ram_we = 1'b1;
                    if (s_q.addr == '0) begin
                        s_d.st = ST_DONE;
                    end else begin
                        s_d.st   = ST_DN_RD;
                        s_d.addr = s_q.addr - 1'b1;
                    end
                end
                ST_DONE: begin
                end
                default: s_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, addr: '0, err: 1'b0, prev: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    march_ram #(
        .DEPTH     (DEPTH),
        .WIDTH     (WIDTH),
        .FAULT_ADDR(FAULT_ADDR)
    ) u_ram (
        .clk  (clk),
        .we   (ram_we),
        .re   (ram_re),
        .addr (s_q.addr),
        .wdata(ram_wdata),
        .fault(fault_i),
        .rdata(ram_rdata)
    );

    assign done_o = (s_q.st == ST_DONE);
    assign err_o  = s_q.err;

    assert_abort_to_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> s_q.st == ST_IDLE);

    assert_start_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_IDLE && en_i && !s_q.prev) |=> (s_q.st == ST_BG && !s_q.err));

    assert_done_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_DONE && en_i) |=> s_q.st == ST_DONE);

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.err && en_i && s_q.st != ST_IDLE) |=> s_q.err);

    assert_err_from_compare_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.err) |-> ($past(s_q.st) == ST_UP_WR || $past(s_q.st) == ST_DN_WR));

endmodule

// File: rtl/dual_mbist_ctl.sv
module dual_mbist_ctl
    import mbist_pkg::*;
#(
    parameter logic [7:0] REG_ADDR   = 8'hA6,
    parameter int         DEPTH      = 64,
    parameter int         WIDTH      = 8,
    parameter int         FAULT_ADDR = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       code_fault,
    input  logic       data_fault
);

    typedef struct packed {
        logic [NUM_ENGINES-1:0] en;
    } ctl_s;

    ctl_s c_d, c_q;
    logic [NUM_ENGINES-1:0] done, err, fault_vec;
    logic                   hit;
    logic                   unused_wbits;

    assign hit          = (reg_addr == REG_ADDR);
    assign fault_vec    = {data_fault, code_fault};
    assign unused_wbits = ^{reg_wdata[7:5], reg_wdata[3:1]};

    always_comb begin
        c_d = c_q;
        if (reg_wr && hit) begin
            for (int g = 0; g < NUM_ENGINES; g++) begin
                c_d.en[g] = reg_wdata[g*FIELD_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    for (genvar g = 0; g < NUM_ENGINES; g++) begin : g_eng
        march_engine #(
            .DEPTH     (DEPTH),
            .WIDTH     (WIDTH),
            .FAULT_ADDR(FAULT_ADDR)
        ) u_eng (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (c_q.en[g]),
            .fault_i(fault_vec[g]),
            .done_o (done[g]),
            .err_o  (err[g])
        );
    end

    always_comb begin
        reg_rdata = '0;
        if (hit) begin
            for (int g = 0; g < NUM_ENGINES; g++) begin
                reg_rdata[g*FIELD_W]     = c_q.en[g];
                reg_rdata[g*FIELD_W + 1] = c_q.en[g] & done[g];
                reg_rdata[g*FIELD_W + 2] = c_q.en[g] & done[g] & err[g];
            end
        end
    end

    assert_foreign_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !hit) |=> $stable(c_q.en));

    assert_enable_follows_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && hit) |=> (c_q.en == {$past(reg_wdata[FIELD_W]), $past(reg_wdata[0])}));

endmodule

// File: tb/sim_dual_mbist_ctl.sv
`timescale 1ns/1ps
module sim_dual_mbist_ctl;

    localparam int DEPTH = 64;
    localparam int LAT   = 5 * DEPTH + 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = 8'hA6;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       code_fault = 1'b0;
    logic       data_fault = 1'b0;

    int compared = 0;
    int failed   = 0;
    string tag = "R1";
    bit finished = 0;

    always #10 clk = ~clk;

    dual_mbist_ctl #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .code_fault(code_fault), .data_fault(data_fault)
    );

    // behavioural model: enable, countdown to done, fault latched at start
    bit m_en [2];
    int m_cnt [2];
    bit m_flt [2];

    always @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            bit nxt;
            if (!rst_n) begin
                m_en[i] = 0; m_cnt[i] = 0; m_flt[i] = 0;
            end else begin
                nxt = (reg_wr && reg_addr == 8'hA6) ? reg_wdata[i*4] : m_en[i];
                if (nxt && !m_en[i]) begin
                    m_cnt[i] = LAT;
                    m_flt[i] = (i == 0) ? code_fault : data_fault;
                end else if (m_cnt[i] > 0) begin
                    m_cnt[i] = m_cnt[i] - 1;
                end
                m_en[i] = nxt;
            end
        end
    end

    function automatic logic [7:0] model_rd();
        logic [7:0] v = 8'h00;
        if (reg_addr != 8'hA6) return v;
        for (int i = 0; i < 2; i++) begin
            bit dn = m_en[i] && m_cnt[i] == 0;
            v[i*4]     = m_en[i];
            v[i*4 + 1] = dn;
            v[i*4 + 2] = dn && m_flt[i];
        end
        return v;
    endfunction

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [7:0] e;
            e = model_rd();
            compared++;
            if (reg_rdata !== e) begin
                failed++;
                $display("FAIL %s (per-cycle) rdata=%h expected=%h at %0t", tag, reg_rdata, e, $time);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_addr = 8'hA6;
    endtask

    task automatic chk(input string r, input logic [7:0] exp);
        @(negedge clk);
        compared++;
        if (reg_rdata !== exp) begin
            failed++;
            $display("FAIL %s rdata=%h expected=%h at %0t", r, reg_rdata, exp, $time);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        chk("R1", 8'h00);

        tag = "R3";
        wr(8'hA6, 8'hEE);
        chk("R3", 8'h00);
        wr(8'hA7, 8'h11);
        chk("R3", 8'h00);
        idle(2);

        tag = "R1";
        reg_addr = 8'hA5;
        chk("R1", 8'h00);
        reg_addr = 8'hA6;

        tag = "R7";
        wr(8'hA6, 8'h11);
        chk("R2", 8'h11);
        idle(200);
        chk("R5", 8'h11);
        idle(LAT);
        chk("R7", 8'h33);

        tag = "R4";
        wr(8'hA6, 8'h01);
        chk("R4", 8'h03);
        wr(8'hA6, 8'h00);
        chk("R4", 8'h00);

        tag = "R9";
        code_fault = 1'b1;
        wr(8'hA6, 8'h11);
        idle(200);
        chk("R5", 8'h11);
        idle(LAT);
        chk("R9", 8'h37);
        chk("R6", 8'h37);
        wr(8'hA6, 8'h00);
        code_fault = 1'b0;

        data_fault = 1'b1;
        wr(8'hA6, 8'h11);
        idle(LAT + 5);
        chk("R9", 8'h73);
        wr(8'hA6, 8'h00);
        data_fault = 1'b0;

        tag = "R10";
        wr(8'hA6, 8'h11);
        idle(LAT + 5);
        chk("R10", 8'h33);
        wr(8'hA6, 8'h00);

        tag = "R8";
        wr(8'hA6, 8'h01);
        idle(150);
        wr(8'hA6, 8'h00);
        chk("R8", 8'h00);
        wr(8'hA6, 8'h01);
        idle(200);
        chk("R8", 8'h01);
        idle(LAT);
        chk("R8", 8'h03);

        tag = "R4";
        wr(8'hA6, 8'h11);
        chk("R4", 8'h13);
        idle(LAT + 5);
        chk("R4", 8'h33);
        wr(8'hA6, 8'hFF);
        chk("R3", 8'h33);
        wr(8'hA6, 8'h00);
        chk("R4", 8'h00);
        idle(5);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, failed);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            finished = 1;
            compared++;
            failed++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, failed);
            $finish;
        end
    end

endmodule